// File: doc/BRIEF.md
# Two-Target Microsequencer With Condition Select

This block is the control half of a microprogrammed register-transfer system. It keeps the current microaddress in a state register and holds the microinstruction stored at that address in a second register. The microinstruction drives the datapath: each register group gets a multiplexor select and a clock enable. A test field in the word picks one of the datapath status lines. That one bit then decides which of the two address fields in the word, A or B, becomes the next microaddress. Nothing is incremented. Each successor, sequential steps included, is named in the word itself.

All control outputs come from registers, so they depend only on the current state and never on the live status lines. The status lines only steer the next clock edge. The control store is a small constant table built into the block. A synchronous reset returns the unit to microaddress 0.

Top module: `useq_two_target`

## Requirements
- R1: With `rst` high at a rising edge, `uaddr_o` becomes 0 and the control outputs show the word at address 0. Reset takes priority over any branch that is pending in the same cycle.
- R2: `uaddr_o` always shows the current microaddress. `mux_sel_o[2g+1:2g]` and `clk_en_o[g]` show group g's select and enable from the word at that address. In the stored word, each group's select sits directly above its own enable bit.
- R3: The test field t of the current word selects `cond_i[t]`. The other status lines have no effect on the next address.
- R4: If the selected status bit is 0, the next microaddress is field A. If it is 1, the next microaddress is field B.
- R5: The control outputs and `uaddr_o` do not change between clock edges, whatever happens on `cond_i`.
- R6: The built-in program is given below as addr: (select,enable) for groups 0..3; test; A; B.
  - 0: (1,1)(0,0)(0,0)(0,0); t0; 1; 1
  - 1: (0,0)(2,1)(0,0)(0,0); t3; 2; 5
  - 2: (0,0)(0,0)(3,1)(0,0); t0; 3; 3
  - 3: (0,0)(0,0)(0,0)(0,1); t5; 3; 4
  - 4: (2,0)(1,1)(0,0)(0,0); t7; 0; 6
  - 5: (0,0)(0,0)(1,1)(2,1); t0; 0; 0
  - 6: (3,1)(3,1)(3,1)(3,1); t1; 0; 2
  - Every other address is all zero.
- R7: A word whose A and B fields are equal steps to that address whatever the status lines show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_i | input | 8 | Status lines from the datapath |
| uaddr_o | output | 6 | Current microaddress |
| mux_sel_o | output | 8 | Per-group multiplexor select, 2 bits per group |
| clk_en_o | output | 4 | Per-group register clock enable |

## Verification
Two things can fall in the same cycle: reset and a taken branch. The bench raises `rst` while the unit waits at address 3 with `cond_i[5]` high, which would otherwise move it to 4. It then expects address 0 and word 0's controls, not address 4. In a separate check, all status lines are toggled in the middle of a cycle at address 1. The bench then confirms that the outputs stayed put and that only `cond_i[3]` decided the next address.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int DEF_NUM_COND = 8;
  localparam int DEF_ADDR_W   = 6;
  localparam int DEF_NUM_GRP  = 4;
  localparam int DEF_MUX_W    = 2;

  // word width for a given configuration
  function automatic int word_width(input int ncond, input int aw, input int ngrp, input int mw);
    return ngrp * (mw + 1) + $clog2(ncond) + 2 * aw;
  endfunction
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int NUM_COND = useq_pkg::DEF_NUM_COND,
  parameter int ADDR_W   = useq_pkg::DEF_ADDR_W,
  parameter int NUM_GRP  = useq_pkg::DEF_NUM_GRP,
  parameter int MUX_W    = useq_pkg::DEF_MUX_W,
  localparam int SEL_W   = $clog2(NUM_COND),
  localparam int GRP_W   = MUX_W + 1,
  localparam int WORD_W  = useq_pkg::word_width(NUM_COND, ADDR_W, NUM_GRP, MUX_W)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int TEST_LSB = 2 * ADDR_W;
  localparam int GRP_LSB  = TEST_LSB + SEL_W;

  function automatic logic [WORD_W-1:0] entry(input logic [ADDR_W-1:0] addr);
    logic [WORD_W-1:0] w;
    int m [4];
    int c [4];
    int t, a, b;
    m = '{0, 0, 0, 0};
    c = '{0, 0, 0, 0};
    t = 0; a = 0; b = 0;
    case (int'(addr))
      0: begin m[0] = 1; c[0] = 1; a = 1; b = 1; end
      1: begin m[1] = 2; c[1] = 1; t = 3; a = 2; b = 5; end
      2: begin m[2] = 3; c[2] = 1; a = 3; b = 3; end
      3: begin c[3] = 1; t = 5; a = 3; b = 4; end
      4: begin m[0] = 2; m[1] = 1; c[1] = 1; t = 7; a = 0; b = 6; end
      5: begin m[2] = 1; c[2] = 1; m[3] = 2; c[3] = 1; end
      6: begin m = '{3, 3, 3, 3}; c = '{1, 1, 1, 1}; t = 1; a = 0; b = 2; end
      default: ;
    endcase
    w = '0;
    w[ADDR_W-1:0]            = ADDR_W'(b);
    w[TEST_LSB-1:ADDR_W]     = ADDR_W'(a);
    w[GRP_LSB-1:TEST_LSB]    = SEL_W'(t);
    for (int g = 0; g < NUM_GRP; g++) begin
      // group 0 is most significant; select sits above its enable
      w[GRP_LSB + (NUM_GRP - 1 - g) * GRP_W]          = (c[g % 4] != 0);
      w[GRP_LSB + (NUM_GRP - 1 - g) * GRP_W + 1 +: MUX_W] = MUX_W'(m[g % 4]);
    end
    return w;
  endfunction

  assign word_o = entry(addr_i);
endmodule

// File: rtl/useq_cond_mux.sv
module useq_cond_mux #(
  parameter int NUM_COND = useq_pkg::DEF_NUM_COND,
  localparam int SEL_W   = $clog2(NUM_COND)
) (
  input  logic [NUM_COND-1:0] cond_i,
  input  logic [SEL_W-1:0]    test_i,
  output logic                bit_o
);
  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < NUM_COND; i++)
      if (test_i == SEL_W'(i)) bit_o = cond_i[i];
  end
endmodule

// File: rtl/useq_next_sel.sv
module useq_next_sel #(
  parameter int ADDR_W = useq_pkg::DEF_ADDR_W
) (
  input  logic              rst,
  input  logic              pick_b_i,
  input  logic [ADDR_W-1:0] tgt_a_i,
  input  logic [ADDR_W-1:0] tgt_b_i,
  output logic [ADDR_W-1:0] next_o
);
  always_comb begin
    if (rst)           next_o = '0;
    else if (pick_b_i) next_o = tgt_b_i;
    else               next_o = tgt_a_i;
  end
endmodule

// File: rtl/useq_two_target.sv
module useq_two_target #(
  parameter int NUM_COND = useq_pkg::DEF_NUM_COND,
  parameter int ADDR_W   = useq_pkg::DEF_ADDR_W,
  parameter int NUM_GRP  = useq_pkg::DEF_NUM_GRP,
  parameter int MUX_W    = useq_pkg::DEF_MUX_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_COND-1:0]        cond_i,
  output logic [ADDR_W-1:0]          uaddr_o,
  output logic [NUM_GRP*MUX_W-1:0]   mux_sel_o,
  output logic [NUM_GRP-1:0]         clk_en_o
);
  localparam int SEL_W    = $clog2(NUM_COND);
  localparam int GRP_W    = MUX_W + 1;
  localparam int WORD_W   = useq_pkg::word_width(NUM_COND, ADDR_W, NUM_GRP, MUX_W);
  localparam int TEST_LSB = 2 * ADDR_W;
  localparam int GRP_LSB  = TEST_LSB + SEL_W;

  logic [ADDR_W-1:0] upc_q, next_addr;
  logic [WORD_W-1:0] word_q, word_next;
  logic              pick_b;
  logic              rst_q;

  useq_store #(.NUM_COND(NUM_COND), .ADDR_W(ADDR_W), .NUM_GRP(NUM_GRP), .MUX_W(MUX_W)) u_store (
    .addr_i(next_addr), .word_o(word_next)
  );

  useq_cond_mux #(.NUM_COND(NUM_COND)) u_cmux (
    .cond_i(cond_i), .test_i(word_q[GRP_LSB-1:TEST_LSB]), .bit_o(pick_b)
  );

  useq_next_sel #(.ADDR_W(ADDR_W)) u_nsel (
    .rst(rst), .pick_b_i(pick_b),
    .tgt_a_i(word_q[TEST_LSB-1:ADDR_W]), .tgt_b_i(word_q[ADDR_W-1:0]),
    .next_o(next_addr)
  );

  // state and its word advance together
  always_ff @(posedge clk) begin
    upc_q  <= next_addr;
    word_q <= word_next;
    rst_q  <= rst;
  end

  assign uaddr_o = upc_q;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int BASE = GRP_LSB + (NUM_GRP - 1 - g) * GRP_W;
    assign clk_en_o[g]                = word_q[BASE];
    assign mux_sel_o[g*MUX_W +: MUX_W] = word_q[BASE + 1 +: MUX_W];
  end

  // R1
  always_comb begin
    if (rst_q) reset_zero_chk: assert (upc_q == '0);
  end

  // R4
  take_b_chk: assert property (@(posedge clk) disable iff (rst)
    pick_b |=> upc_q == $past(word_q[ADDR_W-1:0]));

  // R4
  take_a_chk: assert property (@(posedge clk) disable iff (rst)
    !pick_b |=> upc_q == $past(word_q[TEST_LSB-1:ADDR_W]));

  // R2
  ctrl_follows_state_chk: assert property (@(posedge clk) disable iff (rst)
    (upc_q == $past(upc_q)) |-> ($stable(mux_sel_o) && $stable(clk_en_o)));
endmodule

// File: tb/test_useq_two_target.sv
module test_useq_two_target;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cond_i = '0;
  logic [5:0] uaddr_o;
  logic [7:0] mux_sel_o;
  logic [3:0] clk_en_o;

  int errors = 0;
  int checks = 0;
  int cur = 0;
  bit done = 0;

  // expected program: select, enable per group, test, A, B
  int t_m [7][4] = '{'{1,0,0,0}, '{0,2,0,0}, '{0,0,3,0}, '{0,0,0,0},
                     '{2,1,0,0}, '{0,0,1,2}, '{3,3,3,3}};
  int t_c [7][4] = '{'{1,0,0,0}, '{0,1,0,0}, '{0,0,1,0}, '{0,0,0,1},
                     '{0,1,0,0}, '{0,0,1,1}, '{1,1,1,1}};
  int t_t [7] = '{0, 3, 0, 5, 7, 0, 1};
  int t_a [7] = '{1, 2, 3, 3, 0, 0, 0};
  int t_b [7] = '{1, 5, 3, 4, 6, 0, 2};

  always #4 clk = ~clk;

  useq_two_target i_useq_two_target (
    .clk(clk), .rst(rst), .cond_i(cond_i),
    .uaddr_o(uaddr_o), .mux_sel_o(mux_sel_o), .clk_en_o(clk_en_o)
  );

  task automatic check_state(input string tag, input int exp);
    logic [7:0] em;
    logic [3:0] ec;
    for (int g = 0; g < 4; g++) begin
      em[g*2 +: 2] = 2'(t_m[exp][g]);
      ec[g]        = (t_c[exp][g] != 0);
    end
    checks++;
    if (uaddr_o !== 6'(exp) || mux_sel_o !== em || clk_en_o !== ec) begin
      errors++;
      $display("FAIL %s: addr=%0d sel=%h en=%b expected addr=%0d sel=%h en=%b",
               tag, uaddr_o, mux_sel_o, clk_en_o, exp, em, ec);
    end
  endtask

  // drive status lines, clock once, check the predicted successor
  task automatic step(input logic [7:0] c, input string tag);
    int nxt;
    cond_i = c;
    nxt = c[t_t[cur]] ? t_b[cur] : t_a[cur];
    @(posedge clk); @(negedge clk);
    cur = nxt;
    check_state(tag, cur);
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    cur = 0;
    check_state(tag, 0);
  endtask

  task automatic scen_reset;
    @(negedge clk);
    do_reset("R1 reset state");
  endtask

  task automatic scen_long_path;
    step(8'h00, "R7 unconditional 0->1");
    step(8'h00, "R4 cond3=0 picks A 1->2");
    step(8'hFF, "R7 equal targets 2->3");
    step(8'h00, "R4 wait at 3 cond5=0");
    step(8'hDF, "R3 other lines high, still 3");
    step(8'h20, "R4 cond5=1 picks B 3->4");
    step(8'h80, "R6 cond7=1 4->6");
    step(8'h00, "R6 cond1=0 6->0");
  endtask

  task automatic scen_short_path;
    step(8'hF7, "R3 cond3 low with others high 0->1");
    step(8'h08, "R4 cond3=1 picks B 1->5");
    step(8'hFF, "R2 word 5 then back to 0");
    step(8'h00, "R6 0->1");
    step(8'h00, "R6 1->2");
    step(8'h00, "R6 2->3");
    step(8'h20, "R6 3->4");
    step(8'h7F, "R4 cond7=0 picks A 4->0");
  endtask

  task automatic scen_moore;
    step(8'h00, "R6 0->1");
    #1 cond_i = 8'hFF;
    #1 check_state("R5 outputs ignore live status", 1);
    cond_i = 8'h00;
    #1 check_state("R5 outputs ignore live status again", 1);
    step(8'hF7, "R3 only cond3 decides 1->2");
  endtask

  task automatic scen_reset_wins;
    step(8'h00, "R6 2->3");
    cond_i = 8'h20;
    do_reset("R1 reset beats pending branch");
    step(8'h00, "R1 runs after reset 0->1");
  endtask

  initial begin
    scen_reset();
    scen_long_path();
    scen_short_path();
    scen_moore();
    scen_reset_wins();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule